// File: doc/BRIEF.md
# Partial Reconfiguration Sequencing Controller

This controller sits in the static part of a device and runs the handshake that surrounds a reload of one reconfigurable partition. A host pulses a start request. The controller then fences off the partition's outputs from the static logic and stops the partition's clock. Only after both steps does it ask an external loader to stream the new partial image. Fetching the image from storage and driving the configuration port belong to the loader, which is seen here only as a request and a done/error reply.

Reloading a partition does not pulse any global set/reset, so partition registers without an explicit reset come up with stale contents. Once the loader reports success, the controller restarts the partition clock and holds the partition reset for a fixed number of cycles, so that synchronous resets take effect. It then releases reset and lets the partition settle for a further count. Only then does it drop the output fence and pulse done to the host. If the loader fails, the partition stays fenced, clock-stopped and in reset, and an error flag stays up until the host starts a new attempt.

Top module: `pr_seq_ctrl`

## Requirements
- R1: Whenever the loader request `ldr_req` is high, `rp_decouple` is high; the fence is raised in a cycle before the request first rises.
- R2: Whenever `ldr_req` is high, `rp_clk_en` is low. The clock is stopped in a cycle before the request rises and stays stopped until the loader answers.
- R3: After `ldr_done`, the controller drives `rp_rst` high with `rp_clk_en` high and `rp_decouple` high for exactly RST_CYCLES (default 16) consecutive cycles. It then drives `rp_rst` low.
- R4: After reset release, `rp_decouple` stays high with the clock running for exactly SETTLE_CYCLES (default 8) cycles. `rp_decouple` is never low while `rp_rst` is high.
- R5: `host_busy` is high from the cycle after an accepted start until the sequence ends. `host_done` is a single-cycle pulse, given only while `rp_decouple` is already low. After a good load, the idle outputs are decouple=0, clk_en=1, rst=0.
- R6: If `ldr_err` is seen while the request is pending (it takes priority over `ldr_done`), the request drops and busy falls. `host_err` rises and holds. Meanwhile the partition is held at decouple=1, clk_en=0, rst=1 until the next `host_start`, which clears `host_err` and begins a fresh attempt.
- R7: `host_start` while `host_busy` is high has no effect: exactly one loader request and one done pulse result per accepted start.
- R8: After system reset, the outputs are decouple=1, clk_en=0, rst=1, busy=0, done=0, err=0, req=0. They stay so until a first load completes.
- R9: `ldr_req` rises once per attempt, stays high until `ldr_done` or `ldr_err` is sampled, and is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| host_start | input | 1 | Start request from the host (sampled in idle or error) |
| host_busy | output | 1 | A reload sequence is in progress |
| host_done | output | 1 | One-cycle pulse at the end of a successful reload |
| host_err | output | 1 | Loader failure, held until the next start |
| ldr_req | output | 1 | Request to the loader to stream the partial image |
| ldr_done | input | 1 | Loader reports the image is fully loaded |
| ldr_err | input | 1 | Loader reports a failure |
| rp_clk_en | output | 1 | Enable for the partition clock gate |
| rp_rst | output | 1 | Partition reset, active high |
| rp_decouple | output | 1 | Fence between partition outputs and static logic |

## Verification
The bench drives the sequence with four loader behaviours. In the first, the loader answers after a short delay. In the second it answers at once, which shows that the fence and clock stop are already in place before the request can be seen. In the third the loader fails after a long wait, which separates the error path from a normal finish. In the fourth, stray start pulses land while the request is pending, which shows whether a busy controller re-arms. A monitor measures the lengths of the reset-hold and settle windows from the partition outputs alone. It also counts request edges and done pulses, so a miscounted window or a duplicated handshake shows up as a wrong number rather than a stuck run.

// File: rtl/pr_seq_ctrl.sv
module pr_seq_ctrl #(
  parameter int RST_CYCLES    = 16,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_start,
  output logic host_busy,
  output logic host_done,
  output logic host_err,
  output logic ldr_req,
  input  logic ldr_done,
  input  logic ldr_err,
  output logic rp_clk_en,
  output logic rp_rst,
  output logic rp_decouple
);

  localparam int MAXC = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_FENCE, S_STOP, S_LOAD, S_HOLD, S_RELEASE, S_UNFENCE, S_FINISH, S_FAIL
  } state_t;

  state_t state;
  logic [CW-1:0] cnt;
  logic live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      live  <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_FAIL: if (host_start) state <= S_FENCE;
        S_FENCE: state <= S_STOP;
        S_STOP:  state <= S_LOAD;
        S_LOAD: begin
          cnt <= '0;
          if (ldr_err) begin
            state <= S_FAIL;
            live  <= 1'b0;
          end else if (ldr_done) begin
            state <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (cnt == HOLD_LAST) begin
            state <= S_RELEASE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RELEASE: begin
          if (cnt == SETTLE_LAST) begin
            state <= S_UNFENCE;
            live  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_UNFENCE: state <= S_FINISH;
        S_FINISH:  state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  logic running;
  assign running = state inside {S_HOLD, S_RELEASE, S_UNFENCE, S_FINISH};

  assign host_busy   = !(state inside {S_IDLE, S_FAIL});
  assign host_done   = (state == S_FINISH);
  assign host_err    = (state == S_FAIL);
  assign ldr_req     = (state == S_LOAD);
  assign rp_decouple = !(state inside {S_UNFENCE, S_FINISH}) && !(state == S_IDLE && live);
  assign rp_clk_en   = running || (live && state inside {S_IDLE, S_FENCE});
  assign rp_rst      = (state inside {S_HOLD, S_FAIL}) || (!live && !running);

  a_r1_req_fenced: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_req |-> rp_decouple);

  a_r1_fence_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldr_req) |-> $past(rp_decouple));

  a_r2_req_clock_off: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_req |-> !rp_clk_en);

  a_r3_release_clocked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rp_rst) |-> rp_clk_en && $past(rp_clk_en));

  a_r4_no_unfence_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_decouple |-> !rp_rst);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  a_r5_done_unfenced: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !rp_decouple);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    host_err && !host_start |=> host_err);

  a_r6_err_safe: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> rp_decouple && !rp_clk_en && rp_rst);

  a_r9_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_req && !ldr_done && !ldr_err |=> ldr_req);

  a_r9_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ldr_req && (ldr_done || ldr_err) |=> !ldr_req);

endmodule

// File: tb/pr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pr_seq_ctrl_tb_top;

  localparam int RSTC = 16;
  localparam int SETC = 8;
  localparam int NV = 4;
  localparam int V_DLY  [NV] = '{3, 0, 10, 5};
  localparam bit V_ERR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0};
  localparam bit V_POKE [NV] = '{1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_start = 1'b0, ldr_done = 1'b0, ldr_err = 1'b0;
  logic host_busy, host_done, host_err, ldr_req, rp_clk_en, rp_rst, rp_decouple;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pr_seq_ctrl #(.RST_CYCLES(RSTC), .SETTLE_CYCLES(SETC)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_busy(host_busy),
    .host_done(host_done), .host_err(host_err), .ldr_req(ldr_req),
    .ldr_done(ldr_done), .ldr_err(ldr_err), .rp_clk_en(rp_clk_en),
    .rp_rst(rp_rst), .rp_decouple(rp_decouple));

  int hold_run = 0, last_hold = 0, settle_run = 0, last_settle = 0;
  int done_cnt = 0, req_edges = 0, viol = 0;
  bit prev_hold = 1'b0, prev_done = 1'b0, prev_req = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ldr_req && (!rp_decouple || rp_clk_en)) viol++;
      if (!rp_decouple && rp_rst) viol++;
      if (host_done && (rp_decouple || prev_done)) viol++;
      if (host_done) done_cnt++;
      if (ldr_req && !prev_req) req_edges++;
      if (rp_rst && rp_clk_en && rp_decouple) hold_run++;
      else if (hold_run != 0) begin last_hold = hold_run; hold_run = 0; end
      if (!rp_rst && rp_clk_en && rp_decouple && (settle_run != 0 || prev_hold)) settle_run++;
      else if (settle_run != 0) begin last_settle = settle_run; settle_run = 0; end
      prev_hold = rp_rst && rp_clk_en && rp_decouple;
      prev_done = host_done;
      prev_req  = ldr_req;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic run_case(input int i);
    int d0, r0;
    d0 = done_cnt;
    r0 = req_edges;
    last_hold = 0;
    last_settle = 0;
    host_start = 1'b1;
    tick();
    host_start = 1'b0;
    check("R5 busy after start", host_busy, 1);
    check("R6 err cleared by start", host_err, 0);
    while (!ldr_req) tick();
    if (V_POKE[i]) begin
      host_start = 1'b1;
      tick();
      host_start = 1'b0;
    end
    for (int k = 0; k < V_DLY[i]; k++) tick();
    check("R9 req held while loader works", ldr_req, 1);
    if (V_ERR[i]) ldr_err = 1'b1; else ldr_done = 1'b1;
    tick();
    ldr_done = 1'b0;
    ldr_err = 1'b0;
    check("R9 req dropped after reply", ldr_req, 0);
    if (V_POKE[i]) begin
      host_start = 1'b1;
      tick();
      host_start = 1'b0;
    end
    while (host_busy) tick();
    tick();
    tick();
    check("R7 one request per start", req_edges - r0, 1);
    if (V_ERR[i]) begin
      check("R6 err held", host_err, 1);
      check("R6 fenced", rp_decouple, 1);
      check("R6 clock off", rp_clk_en, 0);
      check("R6 in reset", rp_rst, 1);
      check("R6 no done", done_cnt - d0, 0);
    end else begin
      check("R3 reset hold length", last_hold, RSTC);
      check("R4 settle length", last_settle, SETC);
      check("R5 done pulses", done_cnt - d0, 1);
      check("R5 idle fence off", rp_decouple, 0);
      check("R5 idle clock on", rp_clk_en, 1);
      check("R5 idle reset off", rp_rst, 0);
      check("R6 no err", host_err, 0);
    end
    check("R1 R2 R4 ordering violations", viol, 0);
  endtask

  initial begin
    repeat (3) tick();
    check("R8 fence", rp_decouple, 1);
    check("R8 clock", rp_clk_en, 0);
    check("R8 reset", rp_rst, 1);
    check("R8 busy", host_busy, 0);
    check("R8 done", host_done, 0);
    check("R8 err", host_err, 0);
    check("R8 req", ldr_req, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R8 holds before first load", {rp_decouple, rp_clk_en, rp_rst}, 3'b101);
    ldr_done = 1'b1;
    tick();
    ldr_done = 1'b0;
    check("R8 stray loader done ignored", host_busy, 0);
    for (int i = 0; i < NV; i++) run_case(i);
    host_start = 1'b1;
    tick();
    host_start = 1'b0;
    check("R1 fence up in first step", rp_decouple, 1);
    check("R2 clock still on before stop", rp_clk_en, 1);
    tick();
    check("R2 clock stopped", rp_clk_en, 0);
    check("R1 R2 req not yet", ldr_req, 0);
    tick();
    check("R9 req raised", ldr_req, 1);
    ldr_done = 1'b1;
    ldr_err = 1'b1;
    tick();
    ldr_done = 1'b0;
    ldr_err = 1'b0;
    check("R6 err wins over done", host_err, 1);
    check("R6 busy falls", host_busy, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule